// File: doc/BRIEF.md
# Banked General Register File with DSP Address Taps

This block holds the sixteen 32-bit general registers of a RISC core. Registers 0 to 7 exist in two copies, called bank 0 and bank 1. Registers 8 to 15 have one copy that both banks share. The copy in use is set by two inputs: the privilege input and the bank bit. In user mode the core always works on bank 0. In privileged mode the bank bit picks the bank.

The core reads the file through two general read ports and writes it through one write port. Each of these ports is addressed by a 4-bit register number. Fixed registers are also driven on dedicated tap outputs, so that parallel DSP address generation can use them without taking a read port:
- an X-memory address/index pair;
- a Y-memory address/index pair;
- a single-data address/index pair;
- the stack pointer, register 15;
- the index register, register 0.

A separate alternate-bank port lets privileged code move data to and from the inactive copy of registers 0 to 7.

Writes take effect on the rising clock edge. Every read path is combinational and write-first: a read of a register that is being written in the same cycle returns the value being written.

Top module: `banked_regfile`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, every register in both banks and every shared register clears to zero.
- R2: A write through `wrEn`/`wrAddr`/`wrData` is stored at the rising edge. Every read path is combinational. A read of the register being written in the same cycle returns `wrData`.
- R3: When `privMode` is 0, register numbers 0 to 7 on every port and tap refer to bank 0, whatever the value of `bankBit`.
- R4: When `privMode` is 1, register numbers 0 to 7 refer to bank 0 if `bankBit` is 0 and to bank 1 if `bankBit` is 1.
- R5: Registers 8 to 15 have a single copy, which is seen identically from both banks and in both modes.
- R6: `spOut` always shows register 15. `r0Out` always shows register 0 of the active bank.
- R7: `xAddr` shows register 4 when `xSel` is 0 and register 5 when `xSel` is 1. `xIndex` always shows register 8.
- R8: `yAddr` shows register 6 when `ySel` is 0 and register 7 when `ySel` is 1. `yIndex` always shows register 9.
- R9: `sAddr` shows register 2, 3, 4 or 5 for `sSel` values 0, 1, 2 or 3. `sIndex` always shows register 8.
- R10: When `privMode` is 1, the alternate port reaches the inactive copy of register `altAddr` (0 to 7). `altRdData` reads that copy, write-first. `altWrEn` writes it at the rising edge.
- R11: When `privMode` is 0, the alternate port has no effect: `altWrEn` changes no register, and `altRdData` reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| privMode | input | 1 | 1 = privileged mode |
| bankBit | input | 1 | Bank select, used only in privileged mode |
| rdAddrA | input | 4 | Read port A register number |
| rdDataA | output | 32 | Read port A data |
| rdAddrB | input | 4 | Read port B register number |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 4 | Write register number |
| wrData | input | 32 | Write data |
| altWrEn | input | 1 | Alternate-bank write enable |
| altAddr | input | 3 | Alternate-bank register number (0 to 7) |
| altWrData | input | 32 | Alternate-bank write data |
| altRdData | output | 32 | Alternate-bank read data |
| xSel | input | 1 | X address tap select |
| ySel | input | 1 | Y address tap select |
| sSel | input | 2 | Single-data address tap select |
| xAddr | output | 32 | X-memory address tap |
| xIndex | output | 32 | X-memory index tap |
| yAddr | output | 32 | Y-memory address tap |
| yIndex | output | 32 | Y-memory index tap |
| sAddr | output | 32 | Single-data address tap |
| sIndex | output | 32 | Single-data index tap |
| spOut | output | 32 | Stack pointer (register 15) |
| r0Out | output | 32 | Index register (register 0) |

## Verification
The bench writes a low register in user mode while the bank bit is set. A design that honoured the bank bit outside privileged mode would put that value into bank 1. The bench also reads a register that is being written in the same cycle, on the ports and on the taps. A read-first design would return the old value there. The bench issues alternate-port writes in user mode and then looks at bank 1 from privileged mode: a leak would show up as a changed register. It also checks alternate writes from privileged mode, which a design that swapped active and inactive would send into the visible bank. Finally, it writes shared registers from one bank and reads them from the other, which exposes any duplication of registers 8 to 15.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int DATA_W     = 32;
  localparam int NUM_ARCH   = 16;
  localparam int NUM_BANKED = 8;
  localparam int ARCH_W     = $clog2(NUM_ARCH);
  localparam int BANK_W     = $clog2(NUM_BANKED);
  localparam int NUM_PHYS   = NUM_ARCH + NUM_BANKED;
  localparam int PHYS_W     = $clog2(NUM_PHYS);

  // Architectural register numbers wired to the fixed taps.
  localparam int REG_IDX0   = 0;
  localparam int REG_SP     = 15;
  localparam int X_BASE     = 4;
  localparam int Y_BASE     = 6;
  localparam int S_BASE     = 2;
  localparam int X_IDXREG   = 8;
  localparam int Y_IDXREG   = 9;
  localparam int S_IDXREG   = 8;

  typedef logic [PHYS_W-1:0] physIdx_t;

  // Write strobes from control to datapath.
  typedef struct packed {
    logic     gpWe;
    physIdx_t gpIdx;
    logic     altWe;
    physIdx_t altIdx;
  } wrStrobe_t;

  // Physical entry each read path should drive.
  typedef struct packed {
    physIdx_t rdA;
    physIdx_t rdB;
    physIdx_t altRd;
    physIdx_t xA;
    physIdx_t xI;
    physIdx_t yA;
    physIdx_t yI;
    physIdx_t sA;
    physIdx_t sI;
    physIdx_t sp;
    physIdx_t r0;
  } rdSel_t;
endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import bankreg_pkg::*;
(
  input  logic              privMode,
  input  logic              bankBit,
  input  logic              wrEn,
  input  logic [ARCH_W-1:0] wrAddr,
  input  logic              altWrEn,
  input  logic [BANK_W-1:0] altAddr,
  input  logic [ARCH_W-1:0] rdAddrA,
  input  logic [ARCH_W-1:0] rdAddrB,
  input  logic              xSel,
  input  logic              ySel,
  input  logic [1:0]        sSel,
  output wrStrobe_t         strb,
  output rdSel_t            sel,
  output logic              altOk
);
  // Physical layout: [0..7] bank 0, [8..15] bank 1, [16..23] shared regs 8..15.
  function automatic physIdx_t mapReg(input logic [ARCH_W-1:0] r, input logic bank);
    physIdx_t idx;
    if (int'(r) < NUM_BANKED)
      idx = bank ? PHYS_W'(NUM_BANKED + int'(r)) : PHYS_W'(r);
    else
      idx = PHYS_W'(int'(r) + NUM_BANKED);
    return idx;
  endfunction

  logic activeBank;
  logic otherBank;

  always_comb begin
    activeBank = privMode & bankBit;
    otherBank  = ~activeBank;
    altOk      = privMode;

    strb.gpWe   = wrEn;
    strb.gpIdx  = mapReg(wrAddr, activeBank);
    strb.altWe  = altWrEn & privMode;
    strb.altIdx = mapReg(ARCH_W'(altAddr), otherBank);

    sel.rdA   = mapReg(rdAddrA, activeBank);
    sel.rdB   = mapReg(rdAddrB, activeBank);
    sel.altRd = mapReg(ARCH_W'(altAddr), otherBank);
    sel.xA    = mapReg(ARCH_W'(X_BASE + int'(xSel)), activeBank);
    sel.xI    = mapReg(ARCH_W'(X_IDXREG), activeBank);
    sel.yA    = mapReg(ARCH_W'(Y_BASE + int'(ySel)), activeBank);
    sel.yI    = mapReg(ARCH_W'(Y_IDXREG), activeBank);
    sel.sA    = mapReg(ARCH_W'(S_BASE + int'(sSel)), activeBank);
    sel.sI    = mapReg(ARCH_W'(S_IDXREG), activeBank);
    sel.sp    = mapReg(ARCH_W'(REG_SP), activeBank);
    sel.r0    = mapReg(ARCH_W'(REG_IDX0), activeBank);
  end
endmodule

// File: rtl/regfile_dp.sv
module regfile_dp
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  wrStrobe_t         strb,
  input  rdSel_t            sel,
  input  logic              altOk,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] altWrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] altRdData,
  output logic [DATA_W-1:0] xAddr,
  output logic [DATA_W-1:0] xIndex,
  output logic [DATA_W-1:0] yAddr,
  output logic [DATA_W-1:0] yIndex,
  output logic [DATA_W-1:0] sAddr,
  output logic [DATA_W-1:0] sIndex,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] r0Out
);
  logic [DATA_W-1:0] regs     [NUM_PHYS];
  logic [DATA_W-1:0] nextRegs [NUM_PHYS];

  // The two write ports never target the same entry: alt reaches only the inactive bank.
  for (genvar i = 0; i < NUM_PHYS; i++) begin : g_entry
    always_comb begin
      if (strb.gpWe && strb.gpIdx == PHYS_W'(i))
        nextRegs[i] = wrData;
      else if (strb.altWe && strb.altIdx == PHYS_W'(i))
        nextRegs[i] = altWrData;
      else
        nextRegs[i] = regs[i];
    end

    always_ff @(posedge clk) begin
      if (rst) regs[i] <= '0;
      else     regs[i] <= nextRegs[i];
    end
  end

  // Write-first: all read paths look at the post-write view.
  always_comb begin
    rdDataA   = nextRegs[sel.rdA];
    rdDataB   = nextRegs[sel.rdB];
    altRdData = altOk ? nextRegs[sel.altRd] : '0;
    xAddr     = nextRegs[sel.xA];
    xIndex    = nextRegs[sel.xI];
    yAddr     = nextRegs[sel.yA];
    yIndex    = nextRegs[sel.yI];
    sAddr     = nextRegs[sel.sA];
    sIndex    = nextRegs[sel.sI];
    spOut     = nextRegs[sel.sp];
    r0Out     = nextRegs[sel.r0];
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              privMode,
  input  logic              bankBit,
  input  logic [ARCH_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ARCH_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ARCH_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              altWrEn,
  input  logic [BANK_W-1:0] altAddr,
  input  logic [DATA_W-1:0] altWrData,
  output logic [DATA_W-1:0] altRdData,
  input  logic              xSel,
  input  logic              ySel,
  input  logic [1:0]        sSel,
  output logic [DATA_W-1:0] xAddr,
  output logic [DATA_W-1:0] xIndex,
  output logic [DATA_W-1:0] yAddr,
  output logic [DATA_W-1:0] yIndex,
  output logic [DATA_W-1:0] sAddr,
  output logic [DATA_W-1:0] sIndex,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] r0Out
);
  wrStrobe_t strb;
  rdSel_t    sel;
  logic      altOk;

  regfile_ctrl u_ctrl (
    .privMode (privMode),
    .bankBit  (bankBit),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .altWrEn  (altWrEn),
    .altAddr  (altAddr),
    .rdAddrA  (rdAddrA),
    .rdAddrB  (rdAddrB),
    .xSel     (xSel),
    .ySel     (ySel),
    .sSel     (sSel),
    .strb     (strb),
    .sel      (sel),
    .altOk    (altOk)
  );

  regfile_dp u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .sel       (sel),
    .altOk     (altOk),
    .wrData    (wrData),
    .altWrData (altWrData),
    .rdDataA   (rdDataA),
    .rdDataB   (rdDataB),
    .altRdData (altRdData),
    .xAddr     (xAddr),
    .xIndex    (xIndex),
    .yAddr     (yAddr),
    .yIndex    (yIndex),
    .sAddr     (sAddr),
    .sIndex    (sIndex),
    .spOut     (spOut),
    .r0Out     (r0Out)
  );
endmodule

// File: rtl/regfile_chk.sv
module regfile_chk
  import bankreg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              privMode,
  input logic              bankBit,
  input logic [ARCH_W-1:0] rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [ARCH_W-1:0] rdAddrB,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [ARCH_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              altWrEn,
  input logic [BANK_W-1:0] altAddr,
  input logic [DATA_W-1:0] altWrData,
  input logic [DATA_W-1:0] altRdData,
  input logic              xSel,
  input logic              ySel,
  input logic [1:0]        sSel,
  input logic [DATA_W-1:0] xAddr,
  input logic [DATA_W-1:0] xIndex,
  input logic [DATA_W-1:0] yAddr,
  input logic [DATA_W-1:0] yIndex,
  input logic [DATA_W-1:0] sAddr,
  input logic [DATA_W-1:0] sIndex,
  input logic [DATA_W-1:0] spOut,
  input logic [DATA_W-1:0] r0Out
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && !wrEn |-> (rdDataA == '0 && rdDataB == '0 && spOut == '0)); // R1

  AST_WRITE_BYPASS: assert property (@(posedge clk) disable iff (rst)
    wrEn && wrAddr == rdAddrA |-> rdDataA == wrData); // R2

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(wrEn) && !$past(rst) && rdAddrA == $past(wrAddr) && $stable(privMode) &&
    $stable(bankBit) && !(wrEn && wrAddr == rdAddrA) |-> rdDataA == $past(wrData)); // R2

  AST_USER_BANK: assert property (@(posedge clk) disable iff (rst)
    !privMode && !$past(privMode) && !$past(rst) && !$past(wrEn) && !wrEn &&
    $stable(rdAddrA) |-> $stable(rdDataA)); // R3

  AST_SP_TAP: assert property (@(posedge clk) disable iff (rst)
    rdAddrA == ARCH_W'(REG_SP) |-> rdDataA == spOut); // R6

  AST_R0_TAP: assert property (@(posedge clk) disable iff (rst)
    rdAddrB == ARCH_W'(REG_IDX0) |-> rdDataB == r0Out); // R6

  AST_X_ADDR: assert property (@(posedge clk) disable iff (rst)
    rdAddrA == ARCH_W'(X_BASE + int'(xSel)) |-> rdDataA == xAddr); // R7

  AST_X_INDEX: assert property (@(posedge clk) disable iff (rst)
    rdAddrA == ARCH_W'(X_IDXREG) |-> rdDataA == xIndex); // R7

  AST_Y_ADDR: assert property (@(posedge clk) disable iff (rst)
    rdAddrB == ARCH_W'(Y_BASE + int'(ySel)) |-> rdDataB == yAddr); // R8

  AST_Y_INDEX: assert property (@(posedge clk) disable iff (rst)
    rdAddrB == ARCH_W'(Y_IDXREG) |-> rdDataB == yIndex); // R8

  AST_S_ADDR: assert property (@(posedge clk) disable iff (rst)
    rdAddrB == ARCH_W'(S_BASE + int'(sSel)) |-> rdDataB == sAddr); // R9

  AST_S_INDEX: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> sIndex == xIndex); // R9

  AST_ALT_USER_ZERO: assert property (@(posedge clk) disable iff (rst)
    !privMode |-> altRdData == '0); // R11
endmodule

bind banked_regfile regfile_chk u_chk (.*);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  logic        clk = 1'b0;
  logic        rst, privMode, bankBit, wrEn, altWrEn, xSel, ySel;
  logic [3:0]  rdAddrA, rdAddrB, wrAddr;
  logic [2:0]  altAddr;
  logic [1:0]  sSel;
  logic [31:0] wrData, altWrData;
  logic [31:0] rdDataA, rdDataB, altRdData, xAddr, xIndex, yAddr, yIndex;
  logic [31:0] sAddr, sIndex, spOut, r0Out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mB0 [8], mB1 [8], mHi [8];
  logic [31:0] nB0 [8], nB1 [8], nHi [8];

  always #5 clk = ~clk;

  banked_regfile u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rdModel(input logic [3:0] r, input logic act);
    if (r < 4'd8) return act ? nB1[r[2:0]] : nB0[r[2:0]];
    return nHi[r[2:0]];
  endfunction

  task automatic cyc(input logic r, input logic p, input logic b,
                     input logic we, input logic [3:0] wa, input logic [31:0] wd,
                     input logic awe, input logic [2:0] aa, input logic [31:0] awd,
                     input logic [3:0] ra, input logic [3:0] rb,
                     input logic xs, input logic ys, input logic [1:0] ss);
    logic act;
    @(negedge clk);
    rst = r; privMode = p; bankBit = b; wrEn = we; wrAddr = wa; wrData = wd;
    altWrEn = awe; altAddr = aa; altWrData = awd; rdAddrA = ra; rdAddrB = rb;
    xSel = xs; ySel = ys; sSel = ss;
    #1;
    if (r) begin
      for (int i = 0; i < 8; i++) begin mB0[i] = '0; mB1[i] = '0; mHi[i] = '0; end
      return;
    end
    act = p & b;
    nB0 = mB0; nB1 = mB1; nHi = mHi;
    if (we) begin
      if (wa < 4'd8) begin
        if (act) nB1[wa[2:0]] = wd; else nB0[wa[2:0]] = wd;
      end else nHi[wa[2:0]] = wd;
    end
    if (awe && p) begin
      if (act) nB0[aa] = awd; else nB1[aa] = awd;
    end
    chk("R2 rdDataA", rdDataA, rdModel(ra, act));
    chk("R2 rdDataB", rdDataB, rdModel(rb, act));
    chk("R6 spOut", spOut, rdModel(4'd15, act));
    chk("R6 r0Out", r0Out, rdModel(4'd0, act));
    chk("R7 xAddr", xAddr, rdModel(xs ? 4'd5 : 4'd4, act));
    chk("R7 xIndex", xIndex, rdModel(4'd8, act));
    chk("R8 yAddr", yAddr, rdModel(ys ? 4'd7 : 4'd6, act));
    chk("R8 yIndex", yIndex, rdModel(4'd9, act));
    chk("R9 sAddr", sAddr, rdModel(4'd2 + {2'b00, ss}, act));
    chk("R9 sIndex", sIndex, rdModel(4'd8, act));
    if (p) chk("R10 altRdData", altRdData, act ? nB0[aa] : nB1[aa]);
    else   chk("R11 altRdData", altRdData, 32'h0);
    mB0 = nB0; mB1 = nB1; mHi = nHi;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog all actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin mB0[i] = '0; mB1[i] = '0; mHi[i] = '0; end
    repeat (3) cyc(1,0,0, 0,0,0, 0,0,0, 0,0, 0,0,0);

    // R1: reset state, both banks
    cyc(0,0,0, 0,0,0, 0,0,0, 4'd15,4'd3, 0,0,0);
    chk("R1 sp after reset", spOut, 32'h0);
    chk("R1 r3 bank0 after reset", rdDataB, 32'h0);
    cyc(0,1,1, 0,0,0, 0,3'd3,0, 4'd3,4'd8, 0,0,0);
    chk("R1 r3 bank1 after reset", rdDataA, 32'h0);
    chk("R1 bank0 r3 via alt", altRdData, 32'h0);

    // R3: user mode ignores bankBit
    cyc(0,0,1, 1,4'd3,32'hA5A50003, 0,0,0, 4'd3,4'd0, 0,0,0);
    chk("R2 bypass r3", rdDataA, 32'hA5A50003);
    cyc(0,0,1, 0,0,0, 0,0,0, 4'd3,4'd0, 0,0,0);
    chk("R3 user r3 bank0", rdDataA, 32'hA5A50003);
    cyc(0,0,0, 0,0,0, 0,0,0, 4'd3,4'd0, 0,0,0);
    chk("R3 user r3 bankBit0", rdDataA, 32'hA5A50003);
    // R4: privileged bank selection
    cyc(0,1,1, 0,0,0, 0,0,0, 4'd3,4'd0, 0,0,0);
    chk("R4 priv bank1 r3", rdDataA, 32'h0);
    cyc(0,1,0, 0,0,0, 0,0,0, 4'd3,4'd0, 0,0,0);
    chk("R4 priv bank0 r3", rdDataA, 32'hA5A50003);

    // R5: shared upper registers
    cyc(0,1,1, 1,4'd12,32'h12345678, 0,0,0, 4'd12,4'd12, 0,0,0);
    cyc(0,0,0, 0,0,0, 0,0,0, 4'd12,4'd0, 0,0,0);
    chk("R5 r12 shared", rdDataA, 32'h12345678);
    cyc(0,1,1, 1,4'd15,32'h0000FF00, 0,0,0, 4'd15,4'd0, 0,0,0);
    cyc(0,1,0, 0,0,0, 0,0,0, 4'd15,4'd0, 0,0,0);
    chk("R5 sp shared", spOut, 32'h0000FF00);

    // R11: alt write in user mode ignored
    cyc(0,0,1, 0,0,0, 1,3'd3,32'hDEAD0003, 4'd0,4'd0, 0,0,0);
    chk("R11 alt read user", altRdData, 32'h0);
    cyc(0,1,1, 0,0,0, 0,0,0, 4'd3,4'd0, 0,0,0);
    chk("R11 bank1 r3 untouched", rdDataA, 32'h0);

    // R10: privileged alt write lands in inactive bank
    cyc(0,1,0, 0,0,0, 1,3'd3,32'hBEEF0003, 4'd3,4'd0, 0,0,0);
    chk("R10 active r3 unchanged", rdDataA, 32'hA5A50003);
    cyc(0,1,1, 0,0,0, 0,3'd3,0, 4'd3,4'd0, 0,0,0);
    chk("R10 bank1 r3 from alt", rdDataA, 32'hBEEF0003);
    chk("R10 alt read bank0 r3", altRdData, 32'hA5A50003);

    // R7/R8/R9 tap bypass corner: writing r5 while taps select it
    cyc(0,1,0, 1,4'd5,32'h55550005, 0,0,0, 4'd0,4'd0, 1,0,2'd3);
    chk("R7 xAddr bypass r5", xAddr, 32'h55550005);
    chk("R9 sAddr bypass r5", sAddr, 32'h55550005);

    // Constrained random
    for (int n = 0; n < 4000; n++) begin
      cyc(($urandom % 400) == 0, $urandom % 2, $urandom % 2,
          ($urandom % 3) != 0, 4'($urandom), $urandom,
          ($urandom % 3) == 0, 3'($urandom), $urandom,
          4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule